// File: doc/BRIEF.md
# Mode-Configurable UART Data Queue

This block is the byte-wide holding queue for one direction of a UART channel. A host-side write port pushes bytes into the tail and a read port pops them from the head. Both ports run independently of any serial engine timing. A small control register picks the operating mode. In single-byte holding mode the queue takes one byte and then reports full. In FIFO mode the queue takes 16 or 128 bytes, chosen by a depth-select bit.

The block reports empty, full and the current fill level. It raises a one-cycle overrun pulse when a byte is pushed into a full queue. The control register also carries a flush bit, which empties the queue. Any change between byte mode and FIFO mode empties the queue without a flush command. The clear takes effect one cycle after the control write. While it is pending, the flush bit reads back as 1. Once the clear is done it reads back as 0.

Top module: `uart_mode_fifo`

## Requirements
- R1: After reset the queue is empty, the level is 0, full is low and the control readback is 3'b000 (byte mode, no clear pending, shallow depth).
- R2: With control bit 0 clear (byte mode), the queue holds one entry. Full rises as soon as that entry is written.
- R3: With control bit 0 set (FIFO mode), full rises when the level reaches 16 if control bit 2 is clear, and when it reaches 128 if control bit 2 is set.
- R4: A push while full is discarded. The level and the stored bytes are unchanged.
- R5: A pop while empty changes neither the level nor the head position. The data it returns is undefined.
- R6: Overrun is high for exactly the one cycle after each clock edge at which a push was presented while full was high.
- R7: A control write with bit 1 set, while FIFO mode is already on and stays on, empties the queue at the next clock edge. Bit 1 reads 1 for that one cycle and 0 afterwards. When FIFO mode is off, the same write leaves the queue unchanged and bit 1 reads 0.
- R8: A control write that changes bit 0 in either direction empties the queue at the next clock edge, in the same way as a flush.
- R9: When a clear and a push fall on the same edge, the clear wins and the queue ends up empty.
- R10: A push and a pop on the same edge, with the queue neither empty nor full, leave the level unchanged.
- R11: Bytes leave the head in the order they were pushed, and the head byte is visible on the read data before the pop.
- R12: The level output always equals the number of stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control write data: bit0 FIFO enable, bit1 flush, bit2 deep select |
| ctrl_rdata_o | output | 3 | Control readback; bit1 shows a pending clear |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 8 | Head byte |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue at selected depth |
| level_o | output | 8 | Number of stored entries |
| overrun_o | output | 1 | One-cycle pulse after a push into a full queue |

## Verification
The assertions assume that push and pop may arrive in any combination, including against a full or empty queue. They also assume that a control write can land on any cycle, including while a clear is still pending. The stimulus therefore drives pushes and pops freely against the flags. It issues control writes rarely, so that the queue often fills up to both depth settings. Every clear is followed by at least one cycle with no further control write, so that the one-cycle readback of the flush bit can be observed.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned CTRL_W       = 3;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_FLS_BIT = 1;
  localparam int unsigned CTRL_DEEP_BIT = 2;
endpackage

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic              fifo_en_o,
  output logic              deep_o,
  output logic              clr_o,
  output logic [CTRL_W-1:0] ctrl_rdata_o
);
  logic fifo_en_q, deep_q, pend_q;
  logic mode_chg, flush_req;

  assign mode_chg  = ctrl_wdata_i[CTRL_EN_BIT] != fifo_en_q;
  // flush is only honoured when FIFO mode is on before and after the write
  assign flush_req = ctrl_wdata_i[CTRL_FLS_BIT] & ctrl_wdata_i[CTRL_EN_BIT] & fifo_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      deep_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else if (ctrl_we_i) begin
      fifo_en_q <= ctrl_wdata_i[CTRL_EN_BIT];
      deep_q    <= ctrl_wdata_i[CTRL_DEEP_BIT];
      pend_q    <= mode_chg | flush_req;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end
  end

  assign fifo_en_o = fifo_en_q;
  assign deep_o    = deep_q;
  assign clr_o     = pend_q;

  always_comb begin
    ctrl_rdata_o                = '0;
    ctrl_rdata_o[CTRL_EN_BIT]   = fifo_en_q;
    ctrl_rdata_o[CTRL_FLS_BIT]  = pend_q;
    ctrl_rdata_o[CTRL_DEEP_BIT] = deep_q;
  end

  // R7
  flush_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ctrl_we_i) |=> !pend_q);

  // R8
  mode_change_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && (ctrl_wdata_i[CTRL_EN_BIT] != fifo_en_o)) |=> clr_o);
endmodule

// File: rtl/uart_fifo_ptr.sv
module uart_fifo_ptr #(
  parameter int unsigned MAX_DEPTH = 128,
  localparam int unsigned AW = $clog2(MAX_DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  input  logic [CW-1:0] depth_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = cnt_q == '0;
  // full is set by the selected depth, not by the array size
  assign full_o  = cnt_q >= depth_i;
  assign do_push = push_i & ~full_o & ~clr_i;
  assign do_pop  = pop_i & ~empty_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_en_o   = do_push;
  assign wr_addr_o = wr_q;
  assign rd_addr_o = rd_q;
  assign count_o   = cnt_q;

  // R4
  full_push_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> ($stable(count_o) && $stable(wr_addr_o)));

  // R5
  empty_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> ($stable(rd_addr_o) && $stable(count_o)));

  // R9
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0));

  // R10
  push_pop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o && !full_o && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/uart_fifo_mem.sv
module uart_fifo_mem #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MAX_DEPTH = 128,
  localparam int unsigned AW = $clog2(MAX_DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [MAX_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uart_mode_fifo.sv
module uart_mode_fifo
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned MAX_DEPTH     = 128,
  parameter int unsigned SHALLOW_DEPTH = 16,
  localparam int unsigned AW = $clog2(MAX_DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CW-1:0]     level_o,
  output logic              overrun_o
);
  localparam logic [CW-1:0] DEPTH_BYTE = CW'(1);
  localparam logic [CW-1:0] DEPTH_SHAL = CW'(SHALLOW_DEPTH);
  localparam logic [CW-1:0] DEPTH_DEEP = CW'(MAX_DEPTH);

  logic          fifo_en, deep, clr, wr_en;
  logic [CW-1:0] depth;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          ovr_q;

  uart_fifo_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .fifo_en_o   (fifo_en),
    .deep_o      (deep),
    .clr_o       (clr),
    .ctrl_rdata_o(ctrl_rdata_o)
  );

  always_comb begin
    if (!fifo_en)  depth = DEPTH_BYTE;
    else if (deep) depth = DEPTH_DEEP;
    else           depth = DEPTH_SHAL;
  end

  uart_fifo_ptr #(.MAX_DEPTH(MAX_DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .clr_i    (clr),
    .depth_i  (depth),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .rd_addr_o(rd_addr),
    .count_o  (level_o),
    .empty_o  (empty_o),
    .full_o   (full_o)
  );

  uart_fifo_mem #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(wr_addr),
    .wdata_i(push_data_i),
    .raddr_i(rd_addr),
    .rdata_o(pop_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= push_i & full_o;
  end
  assign overrun_o = ovr_q;

  // R2
  byte_mode_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[CTRL_EN_BIT] && level_o != '0) |-> full_o);

  // R6
  overrun_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> overrun_o);

  // R6
  overrun_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o) |=> !overrun_o);

  // R3
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[CTRL_EN_BIT] && !ctrl_rdata_o[CTRL_DEEP_BIT] && level_o >= CW'(SHALLOW_DEPTH)) |-> full_o);
endmodule

// File: tb/tb_uart_mode_fifo.sv
module tb_uart_mode_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [2:0] ctrl_wd = '0;
  logic [2:0] ctrl_rd;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] pdata = '0, rdata;
  logic       empty, full, ovr;
  logic [7:0] level;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  int  q[$];
  bit  m_en = 0, m_deep = 0, m_pend = 0, m_ovr = 0;

  always #2 clk = ~clk;

  uart_mode_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .ctrl_rdata_o(ctrl_rd), .push_i(push), .push_data_i(pdata), .pop_i(pop),
    .pop_data_o(rdata), .empty_o(empty), .full_o(full), .level_o(level),
    .overrun_o(ovr)
  );

  function automatic int m_depth();
    if (!m_en) return 1;
    return m_deep ? 128 : 16;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit mfull, mempty, nen;
      mfull  = q.size() >= m_depth();
      mempty = q.size() == 0;
      if (m_pend) q.delete();
      else begin
        if (pop && !mempty) void'(q.pop_front());
        if (push && !mfull) q.push_back(int'(pdata));
      end
      m_ovr = push && mfull;
      if (ctrl_we) begin
        nen    = ctrl_wd[0];
        m_pend = (nen != m_en) || (ctrl_wd[1] && nen && m_en);
        m_en   = nen;
        m_deep = ctrl_wd[2];
      end else if (m_pend) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 level", int'(level), q.size());
      chk("R5 empty", int'(empty), int'(q.size() == 0));
      chk("R3 full", int'(full), int'(q.size() >= m_depth()));
      chk("R6 overrun", int'(ovr), int'(m_ovr));
      chk("R7 ctrl readback", int'(ctrl_rd), int'({m_deep, m_pend, m_en}));
      if (q.size() != 0) chk("R11 head data", int'(rdata), q[0]);
    end
  end

  task automatic cyc(input bit p, input int d, input bit o, input bit we, input int wd);
    push = p; pdata = 8'(d); pop = o; ctrl_we = we; ctrl_wd = 3'(wd);
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset empty", int'(empty), 1);
    chk("R1 reset ctrl", int'(ctrl_rd), 0);
    chk("R1 reset full", int'(full), 0);

    // byte mode
    cyc(1, 8'hA5, 0, 0, 0);
    chk("R2 byte full", int'(full), 1);
    chk("R2 byte level", int'(level), 1);
    cyc(1, 8'h3C, 0, 0, 0);
    chk("R6 overrun pulse", int'(ovr), 1);
    chk("R4 data kept", int'(rdata), 8'hA5);
    idle();
    chk("R6 overrun single", int'(ovr), 0);

    // enter FIFO mode, shallow
    cyc(0, 0, 0, 1, 3'b001);
    chk("R8 clear pending", int'(ctrl_rd), 3'b011);
    idle();
    chk("R8 mode change cleared", int'(level), 0);
    chk("R7 bit reads back zero", int'(ctrl_rd), 3'b001);
    for (int i = 0; i < 17; i++) cyc(1, 16 + i, 0, 0, 0);
    chk("R3 shallow full level", int'(level), 16);
    chk("R4 overrun at 16", int'(ovr), 1);
    for (int i = 0; i < 16; i++) begin
      chk("R11 order", int'(rdata), 16 + i);
      cyc(0, 0, 1, 0, 0);
    end
    cyc(0, 0, 1, 0, 0);
    chk("R5 empty pop level", int'(level), 0);
    for (int i = 0; i < 5; i++) cyc(1, 100 + i, 0, 0, 0);
    cyc(1, 200, 1, 0, 0);
    chk("R10 push pop level", int'(level), 5);
    chk("R10 head advanced", int'(rdata), 101);

    // flush in FIFO mode, with push on the clear edge
    cyc(0, 0, 0, 1, 3'b011);
    chk("R7 flush pending", int'(ctrl_rd), 3'b011);
    cyc(1, 77, 0, 0, 0);
    chk("R9 flush wins", int'(level), 0);
    chk("R7 flush bit self clear", int'(ctrl_rd), 3'b001);

    // back to byte mode, flush ignored there
    cyc(1, 9, 0, 1, 3'b000);
    idle();
    chk("R8 leave fifo clears", int'(level), 0);
    cyc(1, 55, 0, 0, 0);
    cyc(0, 0, 0, 1, 3'b010);
    chk("R7 flush ignored in byte mode", int'(ctrl_rd), 0);
    idle();
    chk("R7 byte queue kept", int'(level), 1);

    // deep FIFO mode
    cyc(0, 0, 0, 1, 3'b101);
    idle();
    for (int i = 0; i < 128; i++) cyc(1, i ^ 8'h5A, 0, 0, 0);
    chk("R3 deep full", int'(full), 1);
    chk("R3 deep level", int'(level), 128);
    cyc(1, 0, 0, 0, 0);
    chk("R6 deep overrun", int'(ovr), 1);

    // random traffic across modes
    for (int i = 0; i < 4000; i++) begin
      bit we;
      int wd;
      we = ($urandom % 300) == 0;
      wd = 1 + 4 * ($urandom % 2) + 2 * ($urandom % 2);
      if ($urandom % 5 == 0) wd = $urandom % 8;
      cyc(($urandom % 3) != 0, $urandom % 256, ($urandom % 2) == 0, we, wd);
      if (we) idle();
    end

    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule